// File: doc/BRIEF.md
# Sub-Word Shift and Rotate Unit

A purely combinational shifter for the compact 16-bit shift instructions. A 7-bit opcode chooses one of four operations: shift left, logical shift right, rotate left and arithmetic shift right. A 6-bit operand field is prefix coded and carries both the operand width and an immediate count. Width is byte, halfword or word, and the count shrinks as the width shrinks. The unit shifts the low part of a 32-bit source and returns the result. Source bits above the selected width come out untouched.

The register-pair (long) shift opcodes are recognised but not executed. So are operand fields with no width coding and opcodes outside the shift group. In each of these cases the source passes through unchanged and a flag goes high, so that the surrounding datapath can trap or hand the instruction on. The unit updates no condition code.

Top module: `sub_word_shifter`

## Requirements
- R1: Opcode `11001oo` selects a supported operation from its low two bits: `00` shift left with zero fill, `01` logical shift right with zero fill, `10` rotate left, `11` arithmetic shift right. `long_o` and `unsup_o` are 0 for these opcodes when the field is valid.
- R2: An operand field `0nnnnn` (bit 5 clear) selects 32-bit width, and bits 4:0 give the count 0..31.
- R3: An operand field `10nnnn` selects 16-bit width, and bits 3:0 give the count. Result bits 31:16 equal source bits 31:16.
- R4: An operand field `110nnn` selects 8-bit width, and bits 2:0 give the count. Result bits 31:8 equal source bits 31:8.
- R5: Arithmetic right shift fills the vacated bits with the sign bit of the selected width (bit 7, 15 or 31), not with bit 31 of the source.
- R6: Rotate left wraps the bits around within the selected width only. It keeps the number of set bits in the result equal to that of the source.
- R7: A count of zero returns the source unchanged for every supported operation and width.
- R8: Opcode `11000oo` (a long form) drives `long_o` = 1 and `unsup_o` = 1, and the result equals the source.
- R9: An operand field `111xxx` with a short shift opcode drives `unsup_o` = 1 and `long_o` = 0, and the result equals the source.
- R10: Any opcode outside `1100xxx` drives `unsup_o` = 1 and `long_o` = 0, and the result equals the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 7 | Instruction opcode |
| field_i | input | 6 | Prefix-coded width and count field |
| src_i | input | 32 | Source operand |
| result_o | output | 32 | Shifted or passed-through result |
| long_o | output | 1 | Opcode is a register-pair shift form |
| unsup_o | output | 1 | Operation not executed; source passed through |

## Verification
The unit holds no state, so any decode or lane error shows in the same cycle the inputs are applied. A wrong width decode corrupts upper bits that should pass through, or gives a count taken from the wrong bit slice. A wrong operation decode, or a sign taken from the wrong bit, changes the fill bits. The vector table uses sign bits set and clear at each width, rotations across the lane edge, zero counts and every fallback path, so that each of these faults gives a visible result mismatch.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [1:0] {
    OP_SL  = 2'b00,
    OP_LSR = 2'b01,
    OP_RL  = 2'b10,
    OP_ASR = 2'b11
  } sh_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } sh_size_e;

  localparam logic [4:0] SHORT_GRP = 5'b11001;
  localparam logic [4:0] LONG_GRP  = 5'b11000;
endpackage

// File: rtl/sws_decode.sv
module sws_decode
  import sws_pkg::*;
#(
  parameter int OPC_W   = 7,
  parameter int FIELD_W = 6
) (
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [FIELD_W-1:0] field_i,
  output sh_op_e             op_o,
  output sh_size_e           size_o,
  output logic               long_o,
  output logic               unsup_o
);
  logic is_short;

  assign is_short = (opcode_i[OPC_W-1:2] == SHORT_GRP);
  assign long_o   = (opcode_i[OPC_W-1:2] == LONG_GRP);
  assign op_o     = sh_op_e'(opcode_i[1:0]);

  // prefix code: 0.. word, 10.. half, 110.. byte, 111.. none
  always_comb begin
    if (!field_i[FIELD_W-1])                        size_o = SZ_WORD;
    else if (!field_i[FIELD_W-2])                   size_o = SZ_HALF;
    else if (!field_i[FIELD_W-3])                   size_o = SZ_BYTE;
    else                                            size_o = SZ_NONE;
  end

  assign unsup_o = !is_short || (size_o == SZ_NONE);
endmodule

// File: rtl/sws_lane.sv
module sws_lane
  import sws_pkg::*;
#(
  parameter int LW = 8,
  localparam int CW = $clog2(LW)
) (
  input  sh_op_e          op_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic [LW-1:0]   data_i,
  output logic [LW-1:0]   data_o
);
  logic [2*LW-1:0] dbl;

  assign dbl = {data_i, data_i} << cnt_i;

  always_comb begin
    unique case (op_i)
      OP_SL:   data_o = data_i << cnt_i;
      OP_LSR:  data_o = data_i >> cnt_i;
      OP_RL:   data_o = dbl[2*LW-1:LW];
      OP_ASR:  data_o = LW'($signed(data_i) >>> cnt_i);
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/sub_word_shifter.sv
module sub_word_shifter
  import sws_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OPC_W   = 7,
  localparam int FIELD_W = $clog2(DATA_W) + 1,
  localparam int LANES   = 3
) (
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  src_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               long_o,
  output logic               unsup_o
);
  sh_op_e   op;
  sh_size_e size;
  logic [LANES-1:0][DATA_W-1:0] lane_res;

  sws_decode #(.OPC_W(OPC_W), .FIELD_W(FIELD_W)) u_dec (
    .opcode_i (opcode_i),
    .field_i  (field_i),
    .op_o     (op),
    .size_o   (size),
    .long_o   (long_o),
    .unsup_o  (unsup_o)
  );

  // lane i is DATA_W >> (LANES-1-i) wide: byte, half, word
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LW = DATA_W >> (LANES - 1 - i);
    localparam int CW = $clog2(LW);
    logic [LW-1:0] lane_out;

    sws_lane #(.LW(LW)) u_lane (
      .op_i   (op),
      .cnt_i  (field_i[CW-1:0]),
      .data_i (src_i[LW-1:0]),
      .data_o (lane_out)
    );

    if (LW < DATA_W) begin : g_merge
      assign lane_res[i] = {src_i[DATA_W-1:LW], lane_out};
    end else begin : g_full
      assign lane_res[i] = lane_out;
    end
  end

  always_comb begin
    if (unsup_o) result_o = src_i;
    else         result_o = lane_res[size[1:0] == 2'd3 ? 2'd2 : size[1:0]];
  end
endmodule

// File: rtl/sub_word_shifter_chk.sv
module sub_word_shifter_chk #(
  parameter int DATA_W = 32,
  localparam int OPC_W   = 7,
  localparam int FIELD_W = $clog2(DATA_W) + 1
) (
  input logic [OPC_W-1:0]   opcode_i,
  input logic [FIELD_W-1:0] field_i,
  input logic [DATA_W-1:0]  src_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               long_o,
  input logic               unsup_o
);
  logic short_op, f_word, f_half, f_byte, zero_cnt;

  assign short_op = (opcode_i[6:2] == 5'b11001);
  assign f_word   = !field_i[5];
  assign f_half   = (field_i[5:4] == 2'b10);
  assign f_byte   = (field_i[5:3] == 3'b110);
  assign zero_cnt = (f_word && field_i[4:0] == 5'd0) || (f_half && field_i[3:0] == 4'd0) ||
                    (f_byte && field_i[2:0] == 3'd0);

  always_comb begin
    if (!$isunknown({opcode_i, field_i, src_i, result_o, long_o, unsup_o})) begin
      AST_UNSUP_PASS: assert (!unsup_o || result_o == src_i); // R9
      AST_LONG_FLAG: assert (opcode_i[6:2] != 5'b11000 || (long_o && unsup_o)); // R8
      AST_OTHER_OP: assert (opcode_i[6:3] == 4'b1100 || (unsup_o && !long_o)); // R10
      AST_HALF_UPPER: assert (!(short_op && f_half) || result_o[DATA_W-1:16] == src_i[DATA_W-1:16]); // R3
      AST_BYTE_UPPER: assert (!(short_op && f_byte) || result_o[DATA_W-1:8] == src_i[DATA_W-1:8]); // R4
      AST_ZERO_COUNT: assert (!(short_op && zero_cnt) || result_o == src_i); // R7
      AST_ROT_POP: assert (!(short_op && opcode_i[1:0] == 2'b10) || $countones(result_o) == $countones(src_i)); // R6
      AST_SHORT_FLAGS: assert (!(short_op && (f_word || f_half || f_byte)) || (!unsup_o && !long_o)); // R1
    end
  end
endmodule

bind sub_word_shifter sub_word_shifter_chk #(.DATA_W(DATA_W)) u_chk (
  .opcode_i (opcode_i),
  .field_i  (field_i),
  .src_i    (src_i),
  .result_o (result_o),
  .long_o   (long_o),
  .unsup_o  (unsup_o)
);

// File: tb/sub_word_shifter_bench.sv
module sub_word_shifter_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] opcode;
  logic [5:0] field;
  logic [31:0] src;
  logic [31:0] result;
  logic       long_f, unsup_f;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sub_word_shifter u_sub_word_shifter (
    .opcode_i (opcode),
    .field_i  (field),
    .src_i    (src),
    .result_o (result),
    .long_o   (long_f),
    .unsup_o  (unsup_f)
  );

  // {opcode, field, src, expected, long, unsup, tag}
  localparam int NV = 20;
  localparam logic [86:0] VEC [NV] = '{
    {7'b1100100, 6'b000100, 32'h1234_5678, 32'h2345_6780, 1'b0, 1'b0, 8'd1},
    {7'b1100101, 6'b001000, 32'h8000_00F0, 32'h0080_0000, 1'b0, 1'b0, 8'd1},
    {7'b1100110, 6'b000100, 32'hF000_000F, 32'h0000_00FF, 1'b0, 1'b0, 8'd6},
    {7'b1100111, 6'b000100, 32'h8000_0000, 32'hF800_0000, 1'b0, 1'b0, 8'd5},
    {7'b1100100, 6'b100100, 32'hABCD_1234, 32'hABCD_2340, 1'b0, 1'b0, 8'd3},
    {7'b1100111, 6'b100100, 32'h1111_8000, 32'h1111_F800, 1'b0, 1'b0, 8'd5},
    {7'b1100110, 6'b101000, 32'h5555_12AB, 32'h5555_AB12, 1'b0, 1'b0, 8'd6},
    {7'b1100101, 6'b101111, 32'hFFFF_8000, 32'hFFFF_0001, 1'b0, 1'b0, 8'd3},
    {7'b1100100, 6'b110011, 32'h1234_56FF, 32'h1234_56F8, 1'b0, 1'b0, 8'd4},
    {7'b1100111, 6'b110111, 32'hAAAA_AA80, 32'hAAAA_AAFF, 1'b0, 1'b0, 8'd5},
    {7'b1100110, 6'b110001, 32'h0000_0181, 32'h0000_0103, 1'b0, 1'b0, 8'd6},
    {7'b1100111, 6'b110010, 32'hFFFF_FF40, 32'hFFFF_FF10, 1'b0, 1'b0, 8'd5},
    {7'b1100100, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0, 8'd7},
    {7'b1100110, 6'b100000, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b0, 1'b0, 8'd7},
    {7'b1100011, 6'b000100, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 8'd8},
    {7'b1100000, 6'b000001, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1, 8'd8},
    {7'b1100100, 6'b111010, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, 8'd9},
    {7'b0000000, 6'b000100, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b0, 1'b1, 8'd10},
    {7'b1100101, 6'b110100, 32'h0000_00F0, 32'h0000_000F, 1'b0, 1'b0, 8'd4},
    {7'b1100111, 6'b011111, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd2}
  };

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] o, input logic [5:0] f, input logic [31:0] s);
    @(posedge clk);
    opcode = o;
    field  = f;
    src    = s;
    @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    opcode = '0;
    field  = '0;
    src    = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle inputs: opcode 0 is not a shift, R10
    check("R10 idle", {result, long_f, unsup_f}, {32'h0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][86:80], VEC[i][79:74], VEC[i][73:42]);
      check($sformatf("R%0d vec%0d", VEC[i][7:0], i), {result, long_f, unsup_f}, VEC[i][41:8]);
    end

    // R6: rotate a single byte bit through all positions, upper bits kept
    for (int c = 0; c < 8; c++) begin
      apply(7'b1100110, {3'b110, 3'(c)}, 32'hCCCC_CC01);
      check("R6 byte rotate", {result, long_f, unsup_f}, {32'hCCCC_CC00 | (32'h1 << c), 2'b00});
    end
    // R6: halfword rotate wraps bit 15 into bit 0
    apply(7'b1100110, 6'b100001, 32'h0001_8000);
    check("R6 half wrap", {result, long_f, unsup_f}, {32'h0001_0001, 2'b00});
    // R5: byte sign clear while bit 31 set
    apply(7'b1100111, 6'b110011, 32'h8000_0070);
    check("R5 byte sign", {result, long_f, unsup_f}, {32'h8000_000E, 2'b00});
    // R1: logical right zero fill at half width
    apply(7'b1100101, 6'b100100, 32'hFFFF_F000);
    check("R1 lsr half", {result, long_f, unsup_f}, {32'hFFFF_0F00, 2'b00});
    // R2: word left shift by 31
    apply(7'b1100100, 6'b011111, 32'h0000_0003);
    check("R2 sl 31", {result, long_f, unsup_f}, {32'h8000_0000, 2'b00});
    // R9: field 111 with rotate keeps source
    apply(7'b1100110, 6'b111111, 32'hA5A5_5A5A);
    check("R9 bad field", {result, long_f, unsup_f}, {32'hA5A5_5A5A, 2'b01});
    // R10: neighbour opcode 1101000
    apply(7'b1101000, 6'b000001, 32'h0000_0001);
    check("R10 other op", {result, long_f, unsup_f}, {32'h0000_0001, 2'b01});
    // R8: long arithmetic right form with byte field
    apply(7'b1100011, 6'b110001, 32'hFFFF_FF80);
    check("R8 long byte", {result, long_f, unsup_f}, {32'hFFFF_FF80, 2'b11});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule